// File: doc/BRIEF.md
# Slot-Phase Compare Timer Unit

This unit maintains a local time base for a slotted radio link. A 15-bit phase counter advances on a tick enable. A slot counter sits above it and counts each time the phase wraps. Two 16-bit compare registers are watched against that time base. One schedules the start of a receive or transmit procedure. The other is a general-purpose alarm. Each match can require only the phase to agree, or it can also require compare bit 15 to agree with slot counter bit 0, with an optional inversion. This lets firmware place an event in every slot or only in alternate half-frames.

The phase can be re-aligned to a correction value supplied on an input port. Firmware can request this through a self-clearing control bit. The unit can also do it automatically on every correlator trigger. Each compare match raises a single-cycle event. The event sets a sticky pending bit, and that bit drives an interrupt through a mask. A match on the receive/transmit compare also emits a one-cycle start pulse, provided the external command enable is high.

Top module: `slot_cmp_timer`

## Requirements
- R1: After reset the control, both compare, mask and pending registers read zero, both interrupts and the start pulse are low, and control bits 31..4 always read zero.
- R2: Register offsets: 0x38 control (bit 0 compare-extend enable, bit 1 auto-adjust, bit 2 force load, bit 3 slot-bit invert), 0x3C receive/transmit compare, 0x40 general-purpose compare, 0x44 pending (bit 0 receive/transmit, bit 1 general-purpose), 0x48 mask (same bit layout), 0x4C read-only time base (phase in bits 14..0, slot counter in bits 31..16). Compare registers keep only bits 15..0.
- R3: The phase advances by one on each cycle with tick_en high, wraps from 0x7FFF to 0, and the slot counter increments on that wrap.
- R4: With compare-extend disabled, a compare matches when its bits 14..0 equal the phase; bit 15 and the invert bit have no effect.
- R5: With compare-extend enabled, a match additionally requires compare bit 15 to equal slot bit 0 XOR the invert bit.
- R6: Writing 1 to control bit 2 loads the phase from corr_phase on the next clock edge, and the bit then reads back as 0.
- R7: With auto-adjust set, a corr_trig cycle loads the phase from corr_phase at that clock edge, taking priority over a tick; with auto-adjust clear the trigger is ignored.
- R8: A compare produces one event on the first cycle its condition becomes true. A condition that stays true does not raise the event again after the pending bit is cleared.
- R9: Each interrupt equals its pending bit AND its mask bit. Writing 1 to a pending bit clears it, and a simultaneous event wins over the clear.
- R10: A receive/transmit match raises trx_start for exactly one cycle, and only if start_cmd_en was high. A general-purpose match never raises trx_start. Pending bits and trx_start appear one clock after the match condition arises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Phase advance enable |
| corr_trig | input | 1 | Correlator trigger pulse |
| corr_phase | input | 15 | Phase correction value |
| start_cmd_en | input | 1 | Command enable for the receive/transmit start |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| irq_rxtx | output | 1 | Masked receive/transmit compare interrupt |
| irq_gp | output | 1 | Masked general-purpose compare interrupt |
| trx_start | output | 1 | One-cycle receive/transmit start pulse |

## Verification
A register write lands at the edge that ends its strobe cycle. A forced phase load lands one edge later. A pending bit or start pulse follows the match condition by one further edge. So after a force-load write, interrupts are due two cycles after the write completes, and after a control write that completes a match they are due one cycle after. A triggered load is visible in the cycle right after the trigger edge. The driver pushes each expected output value into a queue tagged with the exact cycle it is due. The monitor samples at the falling edge and compares only the items due in that cycle. This also checks the cycles just before and just after each pulse.

// File: rtl/sct_pkg.sv
package sct_pkg;

    localparam int NUM_CMP  = 2;
    localparam int EV_RXTX  = 0;
    localparam int EV_GP    = 1;

    localparam int OFS_CTRL     = 'h38;
    localparam int OFS_CMP_BASE = 'h3C;
    localparam int OFS_PEND     = 'h44;
    localparam int OFS_MASK     = 'h48;
    localparam int OFS_TBASE    = 'h4C;
    localparam int SLOT_LSB_POS = 16;

    typedef struct packed {
        logic inv_slot;
        logic force_ld;
        logic auto_adj;
        logic ext_en;
    } sct_ctrl_t;

endpackage

// File: rtl/sct_native_clk.sv
module sct_native_clk #(
    parameter int PHASE_W = 15,
    parameter int SLOT_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en_i,
    input  logic               load_i,
    input  logic [PHASE_W-1:0] corr_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic [SLOT_W-1:0]  slot_o
);

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic [SLOT_W-1:0]  slot;
    } clk_st_t;

    clk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.phase = corr_i;
        end else if (tick_en_i) begin
            st_d.phase = st_q.phase + 1'b1;
            if (&st_q.phase) begin
                st_d.slot = st_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase_o = st_q.phase;
    assign slot_o  = st_q.slot;

    AST_LOAD_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.phase == $past(corr_i)));                        // R6
    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en_i && !load_i && (&st_q.phase)) |=>
        ((st_q.phase == '0) && (st_q.slot == $past(st_q.slot) + 1'b1))); // R3
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en_i && !load_i) |=> $stable(st_q));                        // R3

endmodule

// File: rtl/sct_cmp_unit.sv
module sct_cmp_unit #(
    parameter int PHASE_W = 15,
    localparam int CW     = PHASE_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CW-1:0]      cmp_i,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic               slot_lsb_i,
    input  logic               ext_en_i,
    input  logic               inv_i,
    output logic               event_o
);

    typedef struct packed {
        logic hit;
    } cmp_st_t;

    cmp_st_t st_d, st_q;
    logic    phase_eq;
    logic    slot_eq;
    logic    hit_now;

    always_comb begin
        phase_eq  = (cmp_i[PHASE_W-1:0] == phase_i);
        slot_eq   = (cmp_i[CW-1] == (slot_lsb_i ^ inv_i));
        hit_now   = phase_eq && (!ext_en_i || slot_eq);
        st_d.hit  = hit_now;
        event_o   = hit_now && !st_q.hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |=> !event_o);                                             // R8
    AST_EVT_PHASE:  assert property (@(posedge clk) disable iff (!rst_n)
        event_o |-> (cmp_i[PHASE_W-1:0] == phase_i));                      // R4

endmodule

// File: rtl/sct_regfile.sv
module sct_regfile
    import sct_pkg::*;
#(
    parameter int PHASE_W = 15,
    parameter int SLOT_W  = 16,
    parameter int AW      = 8,
    parameter int DW      = 32,
    localparam int CW     = PHASE_W + 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  logic [AW-1:0]                 addr_i,
    input  logic [DW-1:0]                 wdata_i,
    output logic [DW-1:0]                 rdata_o,
    input  logic [NUM_CMP-1:0]            events_i,
    input  logic [PHASE_W-1:0]            phase_i,
    input  logic [SLOT_W-1:0]             slot_i,
    output sct_ctrl_t                     ctrl_o,
    output logic [NUM_CMP-1:0][CW-1:0]    cmp_o,
    output logic [NUM_CMP-1:0]            irq_o
);

    typedef struct packed {
        sct_ctrl_t                     ctrl;
        logic [NUM_CMP-1:0][CW-1:0]    cmp;
        logic [NUM_CMP-1:0]            pend;
        logic [NUM_CMP-1:0]            mask;
    } rf_st_t;

    rf_st_t st_d, st_q;
    logic   wr_ctrl, wr_pend, wr_mask;
    logic   wdata_unused;

    assign wdata_unused = ^wdata_i[DW-1:CW];

    always_comb begin
        wr_ctrl = we_i && (addr_i == AW'(OFS_CTRL));
        wr_pend = we_i && (addr_i == AW'(OFS_PEND));
        wr_mask = we_i && (addr_i == AW'(OFS_MASK));

        st_d = st_q;
        st_d.ctrl.force_ld = 1'b0;
        if (wr_ctrl) begin
            st_d.ctrl = sct_ctrl_t'(wdata_i[3:0]);
        end
        for (int i = 0; i < NUM_CMP; i++) begin
            if (we_i && (addr_i == AW'(OFS_CMP_BASE + 4 * i))) begin
                st_d.cmp[i] = wdata_i[CW-1:0];
            end
        end
        if (wr_mask) begin
            st_d.mask = wdata_i[NUM_CMP-1:0];
        end
        if (wr_pend) begin
            st_d.pend = st_q.pend & ~wdata_i[NUM_CMP-1:0];
        end
        st_d.pend = st_d.pend | events_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == AW'(OFS_CTRL)) begin
            rdata_o[3:0] = st_q.ctrl;
        end
        if (addr_i == AW'(OFS_PEND)) begin
            rdata_o[NUM_CMP-1:0] = st_q.pend;
        end
        if (addr_i == AW'(OFS_MASK)) begin
            rdata_o[NUM_CMP-1:0] = st_q.mask;
        end
        if (addr_i == AW'(OFS_TBASE)) begin
            rdata_o[PHASE_W-1:0]              = phase_i;
            rdata_o[SLOT_LSB_POS +: SLOT_W]   = slot_i;
        end
        for (int i = 0; i < NUM_CMP; i++) begin
            if (addr_i == AW'(OFS_CMP_BASE + 4 * i)) begin
                rdata_o[CW-1:0] = st_q.cmp[i];
            end
        end
    end

    assign ctrl_o = st_q.ctrl;
    assign cmp_o  = st_q.cmp;
    assign irq_o  = st_q.pend & st_q.mask;

    AST_FORCE_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.force_ld && !wr_ctrl) |=> !st_q.ctrl.force_ld);        // R6

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_pend_chk
        AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.pend[g] && !(wr_pend && wdata_i[g])) |=> st_q.pend[g]); // R9
        AST_EVT_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
            events_i[g] |=> st_q.pend[g]);                                 // R8
    end

endmodule

// File: rtl/slot_cmp_timer.sv
module slot_cmp_timer
    import sct_pkg::*;
#(
    parameter int PHASE_W = 15,
    parameter int SLOT_W  = 16,
    parameter int AW      = 8,
    parameter int DW      = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               corr_trig,
    input  logic [PHASE_W-1:0] corr_phase,
    input  logic               start_cmd_en,
    input  logic               reg_we,
    input  logic [AW-1:0]      reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    output logic [DW-1:0]      reg_rdata,
    output logic               irq_rxtx,
    output logic               irq_gp,
    output logic               trx_start
);

    localparam int CW = PHASE_W + 1;

    typedef struct packed {
        logic trx;
    } top_st_t;

    top_st_t                    st_d, st_q;
    sct_ctrl_t                  ctrl;
    logic [NUM_CMP-1:0][CW-1:0] cmp;
    logic [NUM_CMP-1:0]         evt;
    logic [NUM_CMP-1:0]         irq;
    logic [PHASE_W-1:0]         phase;
    logic [SLOT_W-1:0]          slot;
    logic                       load;

    assign load = ctrl.force_ld || (ctrl.auto_adj && corr_trig);

    sct_native_clk #(
        .PHASE_W (PHASE_W),
        .SLOT_W  (SLOT_W)
    ) clk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en_i (tick_en),
        .load_i    (load),
        .corr_i    (corr_phase),
        .phase_o   (phase),
        .slot_o    (slot)
    );

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        sct_cmp_unit #(
            .PHASE_W (PHASE_W)
        ) cmp_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmp_i      (cmp[g]),
            .phase_i    (phase),
            .slot_lsb_i (slot[0]),
            .ext_en_i   (ctrl.ext_en),
            .inv_i      (ctrl.inv_slot),
            .event_o    (evt[g])
        );
    end

    sct_regfile #(
        .PHASE_W (PHASE_W),
        .SLOT_W  (SLOT_W),
        .AW      (AW),
        .DW      (DW)
    ) rf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (reg_we),
        .addr_i   (reg_addr),
        .wdata_i  (reg_wdata),
        .rdata_o  (reg_rdata),
        .events_i (evt),
        .phase_i  (phase),
        .slot_i   (slot),
        .ctrl_o   (ctrl),
        .cmp_o    (cmp),
        .irq_o    (irq)
    );

    always_comb begin
        st_d.trx = evt[EV_RXTX] && start_cmd_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trx_start = st_q.trx;
    assign irq_rxtx  = irq[EV_RXTX];
    assign irq_gp    = irq[EV_GP];

    AST_TRX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        trx_start |-> ($past(start_cmd_en) && $past(evt[EV_RXTX])));       // R10
    AST_TRX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        trx_start |=> !trx_start);                                         // R10

endmodule

// File: tb/slot_cmp_timer_tb.sv
module slot_cmp_timer_tb_top;

    localparam logic [7:0] A_CTRL = 8'h38;
    localparam logic [7:0] A_CRX  = 8'h3C;
    localparam logic [7:0] A_CGP  = 8'h40;
    localparam logic [7:0] A_PEND = 8'h44;
    localparam logic [7:0] A_MASK = 8'h48;
    localparam logic [7:0] A_TB   = 8'h4C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        corr_trig = 1'b0;
    logic [14:0] corr_phase = '0;
    logic        start_cmd_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_rxtx, irq_gp, trx_start;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    typedef struct {
        int    due;
        int    sel;
        logic  val;
        string req;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    slot_cmp_timer dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .corr_trig    (corr_trig),
        .corr_phase   (corr_phase),
        .start_cmd_en (start_cmd_en),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .irq_rxtx     (irq_rxtx),
        .irq_gp       (irq_gp),
        .trx_start    (trx_start)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic obs(input int sel);
        case (sel)
            0:       return irq_rxtx;
            1:       return irq_gp;
            default: return trx_start;
        endcase
    endfunction

    // Monitor: compare every item due in this cycle
    always @(negedge clk) begin
        for (int i = sb_q.size() - 1; i >= 0; i--) begin
            if (sb_q[i].due == cyc) begin
                chk(sb_q[i].req, {31'd0, obs(sb_q[i].sel)}, {31'd0, sb_q[i].val});
                sb_q.delete(i);
            end
        end
    end

    task automatic expect_at(input int dly, input int sel, input logic val, input string req);
        exp_t e;
        e.due = cyc + dly;
        e.sel = sel;
        e.val = val;
        e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(posedge clk); #1;
        reg_addr = a;
        #2;
        chk(req, reg_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        @(posedge clk); #1;
        tick_en = 1'b1;
        repeat (n) @(posedge clk);
        #1;
        tick_en = 1'b0;
    endtask

    task automatic trig(input logic with_tick);
        @(posedge clk); #1;
        corr_trig = 1'b1; tick_en = with_tick;
        @(posedge clk); #1;
        corr_trig = 1'b0; tick_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        reg_addr = A_CTRL; #1; chk("R1", reg_rdata, 32'h0);
        reg_addr = A_CRX;  #1; chk("R1", reg_rdata, 32'h0);
        reg_addr = A_CGP;  #1; chk("R1", reg_rdata, 32'h0);
        reg_addr = A_MASK; #1; chk("R1", reg_rdata, 32'h0);
        reg_addr = A_PEND; #1; chk("R1", reg_rdata, 32'h0);
        chk("R1", {29'd0, irq_rxtx, irq_gp, trx_start}, 32'h0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R2: register map and compare width
        wr(A_CGP, 32'h0000_7000);
        wr(A_CRX, 32'hABCD_0100);
        rd(A_CRX, 32'h0000_0100, "R2");
        rd(A_CGP, 32'h0000_7000, "R2");
        wr(A_MASK, 32'h3);
        rd(A_MASK, 32'h3, "R2");
        wr(A_PEND, 32'h3);
        rd(A_PEND, 32'h0, "R9");

        // R6/R10: forced load hits receive/transmit compare, start enabled
        start_cmd_en = 1'b1;
        corr_phase = 15'h0100;
        wr(A_CTRL, 32'h4);
        expect_at(1, 0, 1'b0, "R6");
        expect_at(2, 0, 1'b1, "R10");
        expect_at(1, 2, 1'b0, "R10");
        expect_at(2, 2, 1'b1, "R10");
        expect_at(3, 2, 1'b0, "R10");
        idle(4);
        rd(A_CTRL, 32'h0, "R6");
        rd(A_TB, 32'h0000_0100, "R6");

        // R8: clearing while condition holds does not re-raise
        wr(A_PEND, 32'h1);
        expect_at(0, 0, 1'b0, "R9");
        expect_at(3, 0, 1'b0, "R8");
        idle(4);

        // R10: start disabled
        start_cmd_en = 1'b0;
        corr_phase = 15'h0050;
        wr(A_CTRL, 32'h4);
        idle(3);
        corr_phase = 15'h0100;
        wr(A_CTRL, 32'h4);
        expect_at(2, 0, 1'b1, "R10");
        expect_at(2, 2, 1'b0, "R10");
        expect_at(3, 2, 1'b0, "R10");
        idle(4);

        // R10: general-purpose match gives no start
        start_cmd_en = 1'b1;
        wr(A_PEND, 32'h1);
        wr(A_CGP, 32'h0000_0200);
        corr_phase = 15'h0200;
        wr(A_CTRL, 32'h4);
        expect_at(2, 1, 1'b1, "R10");
        expect_at(2, 2, 1'b0, "R10");
        idle(4);

        // R9: masking
        wr(A_MASK, 32'h1);
        expect_at(0, 1, 1'b0, "R9");
        rd(A_PEND, 32'h2, "R9");
        wr(A_MASK, 32'h3);
        expect_at(0, 1, 1'b1, "R9");
        idle(2);
        wr(A_PEND, 32'h2);
        expect_at(0, 1, 1'b0, "R9");
        expect_at(2, 1, 1'b0, "R8");
        idle(3);

        // R5: extended compare with slot bit
        wr(A_CGP, 32'h0000_8300);
        wr(A_CTRL, 32'h1);
        corr_phase = 15'h0300;
        wr(A_CTRL, 32'h5);
        expect_at(2, 1, 1'b0, "R5");
        expect_at(3, 1, 1'b0, "R5");
        idle(4);
        wr(A_CTRL, 32'h9);
        expect_at(1, 1, 1'b1, "R5");
        idle(3);

        // R4: bit 15 and invert ignored without extend
        wr(A_PEND, 32'h2);
        wr(A_CTRL, 32'h0);
        wr(A_CGP, 32'h0000_8400);
        wr(A_CTRL, 32'h8);
        corr_phase = 15'h0400;
        wr(A_CTRL, 32'hC);
        expect_at(1, 1, 1'b0, "R4");
        expect_at(2, 1, 1'b1, "R4");
        idle(4);

        // R3: ticking across the wrap, extended match in slot 1
        wr(A_PEND, 32'h3);
        wr(A_CRX, 32'h0000_8001);
        corr_phase = 15'h7FFE;
        wr(A_CTRL, 32'h5);
        idle(3);
        rd(A_TB, 32'h0000_7FFE, "R3");
        ticks(3);
        expect_at(1, 0, 1'b1, "R5");
        rd(A_TB, 32'h0001_0001, "R3");
        idle(2);

        // R7: correlator trigger
        wr(A_PEND, 32'h3);
        wr(A_CTRL, 32'h0);
        corr_phase = 15'h0600;
        trig(1'b0);
        rd(A_TB, 32'h0001_0001, "R7");
        wr(A_CTRL, 32'h2);
        wr(A_CGP, 32'h0000_0600);
        trig(1'b0);
        expect_at(1, 1, 1'b1, "R7");
        rd(A_TB, 32'h0001_0600, "R7");
        corr_phase = 15'h0700;
        trig(1'b1);
        rd(A_TB, 32'h0001_0700, "R7");

        // R1/R6: reserved bits and force self-clear
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, 32'h0000_000B, "R1");

        idle(5);
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R8 actual=%0d expected=0 pending scoreboard items", sb_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule